// File: doc/BRIEF.md
# Character Pixel Serializer with Load Timing

This block turns a stream of character-generator pattern bytes into a one-bit monochrome pixel stream for a text-only composite video output. It runs on the pixel clock and shifts one pattern bit out per rising edge, most significant bit first. A free-running phase counter advances on the falling edge of the pixel clock. From that counter the block derives three outputs: an active-low parallel-load strobe that reloads the shift register once per group of pixels, a request pulse that tells upstream logic to present the next pattern byte, and a processor clock at one eighth of the pixel rate.

The serial pixel is merged with an externally timed sync input into a two-bit composite level code, which drives a small resistor ladder or DAC. During sync the pixel is forced to black. Reset holds the phase counter at zero. On release, the load strobe is already low at the very first rising edge, so the first byte goes out with no lost or extra pixel.

Top module: `char_pixel_serializer`

## Requirements
- R1: While `rst` is high, `load_n_o` is low, `byte_req_o` is low, `cpu_clk_o` is low, `pix_o` is 0, and `lvl_o` is black (2'b01) when `sync_i` is low.
- R2: After `rst` falls, `load_n_o` is low at the first rising edge and at every 8th rising edge after that. It is high at every other rising edge.
- R3: `load_n_o`, `byte_req_o` and `cpu_clk_o` change only after falling edges. Each holds the same value just before and just after every rising edge.
- R4: The shift register takes the byte on `pat_i` at the rising edge where `load_n_o` is low. Values on `pat_i` at other edges have no effect on the pixel stream.
- R5: Pixels leave most significant bit first, one per rising edge, with no gap between groups. In the cycle that follows the k-th edge of a group (k = 0..7), the pixel is bit 7-k of that group's byte.
- R6: `byte_req_o` is high at the rising edge immediately before each load edge (phase 7) and low at all other rising edges.
- R7: `cpu_clk_o` has a period of 8 pixel clocks. It is low at the four rising edges starting with a load edge (phases 0..3) and high at phases 4..7.
- R8: `lvl_o` is 2'b00 (sync) whenever `sync_i` is high. Otherwise it is 2'b01 (black) for pixel 0 and 2'b10 (white) for pixel 1. `pix_o` is 0 whenever `sync_i` is high.
- R9: `sync_i` does not disturb the serializer. When sync ends, the pixel stream continues at the bit position it would have reached without sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Active-high reset, sampled on the rising edge |
| pat_i | input | PIX_W | Pattern byte from the character ROM |
| sync_i | input | 1 | Sync active (high) from external timing logic |
| load_n_o | output | 1 | Active-low parallel-load strobe |
| byte_req_o | output | 1 | High one clock before each load edge |
| cpu_clk_o | output | 1 | Processor clock at pixel clock / PIX_W |
| pix_o | output | 1 | Serial pixel, blanked during sync |
| lvl_o | output | 2 | Composite level code: 00 sync, 01 black, 10 white |

## Verification
The assertions assume that `rst` is held high for at least two rising edges before it is released. They also assume that `pat_i` is settled at every load edge. The capture check compares the register against the value present at that edge, so the bench drives `pat_i` and `sync_i` only 2 ns after a rising edge. The correct byte is put on `pat_i` right after the request pulse and held until the load edge. Between those windows the bench writes random junk to `pat_i`, so any capture outside the load edge shows up as a wrong pixel. Reset is released at two different points in the cycle: just after a rising edge and just after a falling edge. Both cases must produce the same first-edge alignment.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [1:0] {
        LVL_SYNC  = 2'b00,
        LVL_BLACK = 2'b01,
        LVL_WHITE = 2'b10,
        LVL_RSVD  = 2'b11
    } lvl_e;

endpackage

// File: rtl/cps_phase_gen.sv
module cps_phase_gen #(
    parameter int PIX_W = 8
) (
    input  logic clk,
    input  logic rst,
    output logic load_n,
    output logic byte_req,
    output logic cpu_clk
);
    localparam int PH_W = $clog2(PIX_W);
    localparam logic [PH_W-1:0] PH_ONE = 1;

    typedef struct packed {
        logic run;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        pos_d.run = !rst;
        ph_d      = pos_q.run ? (ph_q + PH_ONE) : '0;
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

    // the phase advances on the falling edge, so the strobes are steady at rising edges
    always_ff @(negedge clk) begin
        ph_q <= ph_d;
    end

    assign load_n   = |ph_q;
    assign byte_req = &ph_q;
    assign cpu_clk  = ph_q[PH_W-1];

    // R6: every load edge after the first is preceded by a request edge
    assert_req_before_load_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !$past(rst) && $past(pos_q.run)) |-> $past(byte_req))
        else $error("R6 load without preceding request");

    // R7: processor clock low on load edges, high on request edges
    assert_cpu_low_at_load_R7: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> !cpu_clk)
        else $error("R7 cpu clock high at load");
    assert_cpu_high_at_req_R7: assert property (@(posedge clk) disable iff (rst)
        byte_req |-> cpu_clk)
        else $error("R7 cpu clock low at request");

endmodule

// File: rtl/cps_piso.sv
module cps_piso #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [PIX_W-1:0] pat_i,
    output logic             pix_raw
);
    typedef struct packed {
        logic [PIX_W-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.sr = '0;
        end else if (!load_n) begin
            st_d.sr = pat_i;
        end else begin
            st_d.sr = {st_q.sr[PIX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pix_raw = st_q.sr[PIX_W-1];

    // R4: a load edge captures the pattern input
    assert_load_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_n)) |-> (st_q.sr == $past(pat_i)))
        else $error("R4 pattern not captured");

    // R5: other edges shift toward the MSB
    assert_shift_msb_first_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_n)) |-> (st_q.sr == {$past(st_q.sr[PIX_W-2:0]), 1'b0}))
        else $error("R5 shift mismatch");

endmodule

// File: rtl/cps_lvl_mux.sv
module cps_lvl_mux
    import cps_pkg::*;
(
    input  logic       pix_raw,
    input  logic       sync_i,
    output logic       pix,
    output lvl_e       lvl
);
    always_comb begin
        pix = pix_raw && !sync_i;
        if (sync_i) begin
            lvl = LVL_SYNC;
        end else if (pix_raw) begin
            lvl = LVL_WHITE;
        end else begin
            lvl = LVL_BLACK;
        end
    end
endmodule

// File: rtl/char_pixel_serializer.sv
module char_pixel_serializer
    import cps_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pat_i,
    input  logic             sync_i,
    output logic             load_n_o,
    output logic             byte_req_o,
    output logic             cpu_clk_o,
    output logic             pix_o,
    output logic [1:0]       lvl_o
);
    logic pix_raw;
    lvl_e lvl;

    cps_phase_gen #(.PIX_W(PIX_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n_o),
        .byte_req (byte_req_o),
        .cpu_clk  (cpu_clk_o)
    );

    cps_piso #(.PIX_W(PIX_W)) u_piso (
        .clk     (clk),
        .rst     (rst),
        .load_n  (load_n_o),
        .pat_i   (pat_i),
        .pix_raw (pix_raw)
    );

    cps_lvl_mux u_lvl (
        .pix_raw (pix_raw),
        .sync_i  (sync_i),
        .pix     (pix_o),
        .lvl     (lvl)
    );

    assign lvl_o = lvl;

    // R8: sync dominates the level and blanks the pixel
    assert_blank_sync_R8: assert property (@(posedge clk) disable iff (rst)
        sync_i |-> (lvl_o == 2'b00 && !pix_o))
        else $error("R8 sync not dominant");

endmodule

// File: tb/sim_char_pixel_serializer.sv
module sim_char_pixel_serializer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pat_i = 8'h00;
    logic       sync_i = 1'b0;
    logic       load_n_o, byte_req_o, cpu_clk_o, pix_o;
    logic [1:0] lvl_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int seed_dummy;

    char_pixel_serializer #(.PIX_W(8)) u0 (
        .clk(clk), .rst(rst), .pat_i(pat_i), .sync_i(sync_i),
        .load_n_o(load_n_o), .byte_req_o(byte_req_o), .cpu_clk_o(cpu_clk_o),
        .pix_o(pix_o), .lvl_o(lvl_o)
    );

    always #5 clk = ~clk;

    function automatic logic [1:0] exp_lvl(input logic s, input logic p);
        if (s) return 2'b00;
        return p ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_reset_state();
        chk(load_n_o == 1'b0, "R1 load_n", load_n_o, 0);
        chk(byte_req_o == 1'b0, "R1 byte_req", byte_req_o, 0);
        chk(cpu_clk_o == 1'b0, "R1 cpu_clk", cpu_clk_o, 0);
        chk(pix_o == 1'b0, "R1 pix", pix_o, 0);
        chk(lvl_o == 2'b01, "R1 lvl", lvl_o, 1);
    endtask

    // releases reset and runs n edges; late_rel picks release just after a falling edge
    task automatic run_stream(input int n, input bit late_rel);
        logic [7:0] cur, nxt;
        logic       ld_pre, sync_was;
        int         g;
        logic [7:0] dir [4];
        dir[0] = 8'hA5; dir[1] = 8'h00; dir[2] = 8'hFF; dir[3] = 8'h81;
        g = 0;
        cur = 8'h00;
        nxt = dir[0];
        pat_i = nxt;
        sync_i = 1'b0;
        sync_was = 1'b0;
        if (late_rel) begin
            @(negedge clk); #1 rst = 1'b0;
            #2;
        end else begin
            rst = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            int ph;
            ph = k % 8;
            if (!(k == 0 && late_rel)) begin
                @(negedge clk); #3;
            end
            // just before edge k
            chk(load_n_o == (ph != 0), "R2 load_n period", load_n_o, ph != 0);
            chk(byte_req_o == (ph == 7), "R6 byte_req", byte_req_o, ph == 7);
            chk(cpu_clk_o == (ph >= 4), "R7 cpu_clk", cpu_clk_o, ph >= 4);
            ld_pre = load_n_o;
            @(posedge clk);
            if (ph == 0) begin
                cur = nxt;
                g++;
            end
            #2;
            // just after edge k
            chk(load_n_o == ld_pre, "R3 load stable over rise", load_n_o, ld_pre);
            if (!sync_i && sync_was)
                chk(pix_o == cur[7-ph], "R9 stream after sync", pix_o, cur[7-ph]);
            else
                chk(pix_o == (sync_i ? 1'b0 : cur[7-ph]), "R5 R4 pixel", pix_o,
                    sync_i ? 1'b0 : cur[7-ph]);
            chk(lvl_o == exp_lvl(sync_i, cur[7-ph]), "R8 level", lvl_o,
                exp_lvl(sync_i, cur[7-ph]));
            sync_was = sync_i;
            // drive the next cycle
            if (ph == 7) begin
                nxt = (g < 4) ? dir[g] : 8'($urandom);
                pat_i = nxt;
            end else begin
                pat_i = 8'($urandom);
            end
            sync_i = (k > 40) && (($urandom % 6) == 0);
        end
        sync_i = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        chk_reset_state();
    endtask

    initial begin
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #2;
        chk_reset_state();
        sync_i = 1'b1;
        #1;
        chk(lvl_o == 2'b00, "R8 sync level in reset", lvl_o, 0);
        sync_i = 1'b0;
        #1;
        run_stream(400, 1'b0);
        run_stream(203, 1'b1);
        run_stream(64, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule